// File: doc/BRIEF.md
# ADC Select-Mode Conversion Sequencer

This block is the digital controller for a successive-approximation converter core running in single-channel select mode. Software writes an enable bit and a channel number through a small register port. While the enable bit is set, the sequencer keeps the core busy. It launches a conversion on the chosen input and waits for the core to finish. It then stores the result and launches the next conversion straight away. Each of the ten inputs owns one result register, so a result always lands in the slot whose index matches the converted input.

An end-of-conversion interrupt pulse goes out on every completed conversion. The pulse is in the same cycle in which the stored result becomes readable. Clearing the enable bit halts the sequence. If a conversion is still in flight when enable is cleared, it is dropped: nothing is stored and no interrupt is raised.

The converter core sits outside the block. It is reached through a one-cycle start pulse, a channel number held for the whole conversion, a one-cycle done pulse, and a result bus that is valid while done is high.

Top module: `adc_select_seq`

## Requirements
- R1: Writing a value with bit 0 set to address 0 sets the enable bit. The start pulse follows. With the write in cycle t, the enable register changes at the end of t and `cv_start` is high in cycle t+2.
- R2: The channel number is bits [3:0] of address 1. At each start, `cv_chan` carries that number when it is 0 to 9, and carries 0 when it is 10 to 15.
- R3: When a conversion completes, its data is stored in result register m, where m is the converted channel. Result register m is read at address 16+m. All other result registers keep their values.
- R4: `eoc_irq` is high for exactly one cycle, in the cycle after `cv_done` was accepted. That is the first cycle in which the new result is readable.
- R5: While enable stays 1, `cv_start` is high in the cycle right after each `eoc_irq` pulse.
- R6: When enable was 0 in the previous cycle, `cv_start` is low.
- R7: A conversion is aborted when enable is 0 in the cycle where `cv_done` arrives, or at any point before it. An aborted conversion writes no result and raises no `eoc_irq`. A `cv_done` that arrives while no conversion is running is ignored.
- R8: The channel number is sampled at each start. Changing it during a conversion affects only the next conversion.
- R9: After reset, all result registers read 0, enable reads 0, and `cv_start` and `eoc_irq` are low.
- R10: `cv_start` is a single-cycle pulse, and only one conversion runs at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register write address |
| wr_data | input | 10 | Register write data |
| rd_addr | input | 5 | Register read address |
| rd_data | output | 10 | Register read data (combinational) |
| cv_start | output | 1 | One-cycle conversion start to the core |
| cv_chan | output | 4 | Channel under conversion |
| cv_done | input | 1 | One-cycle completion pulse from the core |
| cv_data | input | 10 | Conversion result, valid with cv_done |
| eoc_irq | output | 1 | End-of-conversion interrupt pulse |

## Verification
All sixteen values of the channel field are swept, each with two back-to-back conversions. The valid values show whether results land in their own slot. The six values beyond the last input show that they fold onto channel 0 and not onto some neighbour. Each result word encodes its channel and a sequence count, so a write to the wrong slot and a stale value can both be told apart. Separate runs change the channel during a conversion, clear enable in the middle of a conversion, and time the first start after an enable write. These runs separate sampling at start from sampling at completion, and an abort from a normal finish.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_BUSY = 1'b1
   } seq_state_t;

endpackage

// File: rtl/adc_seq_regs.sv
module adc_seq_regs #(
   parameter int ADDR_W    = 5,
   parameter int DATA_W    = 10,
   parameter int CH_W      = 4,
   parameter int CTRL_ADDR = 0,
   parameter int SEL_ADDR  = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              en,
   output logic [CH_W-1:0]   sel
);

   localparam logic [ADDR_W-1:0] CtrlA = ADDR_W'(CTRL_ADDR);
   localparam logic [ADDR_W-1:0] SelA  = ADDR_W'(SEL_ADDR);

   logic unused_wr_bits;
   assign unused_wr_bits = ^wr_data[DATA_W-1:CH_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en  <= 1'b0;
         sel <= '0;
      end else if (wr_en) begin
         if (wr_addr == CtrlA) en  <= wr_data[0];
         if (wr_addr == SelA)  sel <= wr_data[CH_W-1:0];
      end
   end

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
   import adc_seq_pkg::*;
#(
   parameter int NCH    = 10,
   parameter int CH_W   = 4,
   parameter int DATA_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [CH_W-1:0]   sel,
   input  logic              cv_done,
   input  logic [DATA_W-1:0] cv_data,
   output logic              cv_start,
   output logic [CH_W-1:0]   cv_chan,
   output logic              res_wr,
   output logic [CH_W-1:0]   res_ch,
   output logic [DATA_W-1:0] res_data,
   output logic              irq
);

   localparam logic [CH_W:0] NchW = (CH_W+1)'(NCH);

   seq_state_t      state;
   logic            start_q;
   logic            irq_q;
   logic [CH_W-1:0] chan_q;
   logic [CH_W-1:0] chan_pick;

   // out-of-range selections fold onto channel 0
   assign chan_pick = ({1'b0, sel} < NchW) ? sel : '0;

   assign res_wr   = (state == ST_BUSY) && en && cv_done;
   assign res_ch   = chan_q;
   assign res_data = cv_data;
   assign cv_start = start_q;
   assign cv_chan  = chan_q;
   assign irq      = irq_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         start_q <= 1'b0;
         irq_q   <= 1'b0;
         chan_q  <= '0;
      end else begin
         start_q <= 1'b0;
         irq_q   <= res_wr;
         unique case (state)
            ST_IDLE: begin
               if (en) begin
                  start_q <= 1'b1;
                  chan_q  <= chan_pick;
                  state   <= ST_BUSY;
               end
            end
            ST_BUSY: begin
               if (!en || cv_done) state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/adc_seq_results.sv
module adc_seq_results #(
   parameter int NCH    = 10,
   parameter int CH_W   = 4,
   parameter int DATA_W = 10
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr,
   input  logic [CH_W-1:0]              wr_ch,
   input  logic [DATA_W-1:0]            wr_data,
   output logic [NCH-1:0][DATA_W-1:0]   bank
);

   for (genvar m = 0; m < NCH; m++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            bank[m] <= '0;
         else if (wr && (wr_ch == CH_W'(m)))
            bank[m] <= wr_data;
      end
   end

endmodule

// File: rtl/adc_select_seq.sv
module adc_select_seq #(
   parameter int NCH       = 10,
   parameter int CH_W      = 4,
   parameter int DATA_W    = 10,
   parameter int ADDR_W    = 5,
   parameter int CTRL_ADDR = 0,
   parameter int SEL_ADDR  = 1,
   parameter int RES_BASE  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              cv_start,
   output logic [CH_W-1:0]   cv_chan,
   input  logic              cv_done,
   input  logic [DATA_W-1:0] cv_data,
   output logic              eoc_irq
);

   localparam int ADDR_SPAN = 1 << ADDR_W;

   if (NCH < 1 || NCH > (1 << CH_W)) begin : g_bad_nch
      $error("NCH must fit in CH_W bits");
   end
   if (DATA_W <= CH_W) begin : g_bad_dw
      $error("DATA_W must exceed CH_W");
   end
   if (RES_BASE + NCH > ADDR_SPAN || RES_BASE <= CTRL_ADDR || RES_BASE <= SEL_ADDR) begin : g_bad_map
      $error("result window must lie above control registers and inside address space");
   end

   logic                       ctrl_en;
   logic [CH_W-1:0]            ctrl_sel;
   logic                       res_wr;
   logic [CH_W-1:0]            res_ch;
   logic [DATA_W-1:0]          res_data;
   logic [NCH-1:0][DATA_W-1:0] bank;

   adc_seq_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CH_W(CH_W),
      .CTRL_ADDR(CTRL_ADDR), .SEL_ADDR(SEL_ADDR)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .en(ctrl_en), .sel(ctrl_sel)
   );

   adc_seq_fsm #(.NCH(NCH), .CH_W(CH_W), .DATA_W(DATA_W)) u_fsm (
      .clk(clk), .rst_n(rst_n), .en(ctrl_en), .sel(ctrl_sel),
      .cv_done(cv_done), .cv_data(cv_data), .cv_start(cv_start),
      .cv_chan(cv_chan), .res_wr(res_wr), .res_ch(res_ch),
      .res_data(res_data), .irq(eoc_irq)
   );

   adc_seq_results #(.NCH(NCH), .CH_W(CH_W), .DATA_W(DATA_W)) u_res (
      .clk(clk), .rst_n(rst_n), .wr(res_wr), .wr_ch(res_ch),
      .wr_data(res_data), .bank(bank)
   );

   always_comb begin
      rd_data = '0;
      if (rd_addr == ADDR_W'(CTRL_ADDR))
         rd_data[0] = ctrl_en;
      else if (rd_addr == ADDR_W'(SEL_ADDR))
         rd_data[CH_W-1:0] = ctrl_sel;
      else begin
         for (int m = 0; m < NCH; m++) begin
            if (rd_addr == ADDR_W'(RES_BASE + m)) rd_data = bank[m];
         end
      end
   end

endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
   parameter int NCH  = 10,
   parameter int CH_W = 4
) (
   input logic            clk,
   input logic            rst_n,
   input logic            en,
   input logic            cv_start,
   input logic [CH_W-1:0] cv_chan,
   input logic            cv_done,
   input logic            eoc_irq
);

   localparam logic [CH_W:0] NchW = (CH_W+1)'(NCH);

   p_start_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cv_start |=> !cv_start);

   p_irq_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      eoc_irq |=> !eoc_irq);

   p_irq_after_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
      eoc_irq |-> $past(cv_done));

   p_chan_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cv_start |-> ({1'b0, cv_chan} < NchW));

   p_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (eoc_irq && en) |=> cv_start);

   p_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !cv_start);

   p_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !eoc_irq);

endmodule

bind adc_select_seq adc_seq_chk #(.NCH(NCH), .CH_W(CH_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .en(ctrl_en), .cv_start(cv_start),
   .cv_chan(cv_chan), .cv_done(cv_done), .eoc_irq(eoc_irq)
);

// File: tb/adc_select_seq_tb.sv
module adc_select_seq_tb;

   localparam int LAT = 6;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [4:0] wr_addr = '0;
   logic [9:0] wr_data = '0;
   logic [4:0] rd_addr = '0;
   logic [9:0] rd_data;
   logic       cv_start;
   logic [3:0] cv_chan;
   logic       cv_done = 1'b0;
   logic [9:0] cv_data = '0;
   logic       eoc_irq;

   int errors = 0;
   int checks = 0;
   int irq_cnt = 0;
   int start_cnt = 0;
   int seq = 0;
   int lat_cnt = 0;
   logic [3:0] m_chan = '0;
   logic [3:0] last_irq_chan = '0;
   logic [9:0] exp_res [10];
   bit en_sh = 1'b0;
   bit en_prev = 1'b0;
   bit conv_live = 1'b0;
   bit irq_due = 1'b0;
   bit restart_due = 1'b0;
   logic [3:0] sel_sh = '0;

   always #5 clk = ~clk;

   adc_select_seq u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .cv_start(cv_start), .cv_chan(cv_chan), .cv_done(cv_done),
      .cv_data(cv_data), .eoc_irq(eoc_irq)
   );

   function automatic logic [3:0] mapch(input logic [3:0] s);
      return (s < 4'd10) ? s : 4'd0;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // converter model and output monitor, all at the falling edge
   always @(negedge clk) begin
      if (!rst_n) begin
         cv_done = 1'b0;
         lat_cnt = 0;
         conv_live = 1'b0;
         irq_due = 1'b0;
         restart_due = 1'b0;
      end else begin
         // R4 / R7: interrupt only for a live, still-enabled conversion
         if (irq_due || eoc_irq) begin
            chk(eoc_irq == irq_due, "R4/R7 irq after done", eoc_irq, irq_due);
         end
         if (eoc_irq && irq_due) begin
            exp_res[m_chan] = cv_data;
            last_irq_chan = m_chan;
            irq_cnt++;
         end
         // R5 restart
         if (restart_due) chk(cv_start == 1'b1, "R5 restart after irq", cv_start, 1);
         // R6 stop
         if (!en_prev) chk(cv_start == 1'b0, "R6 no start while disabled", cv_start, 0);
         restart_due = eoc_irq && en_sh;
         irq_due = 1'b0;
         cv_done = 1'b0;
         if (lat_cnt > 0) begin
            lat_cnt--;
            if (lat_cnt == 0) begin
               cv_done = 1'b1;
               cv_data = {m_chan, 6'(seq)};
               seq++;
               irq_due = conv_live && en_sh;
               conv_live = 1'b0;
            end
         end
         if (!en_sh) conv_live = 1'b0;
         if (cv_start) begin
            chk(cv_chan == mapch(sel_sh), "R2 channel at start", cv_chan, mapch(sel_sh));
            m_chan = cv_chan;
            lat_cnt = LAT;
            conv_live = 1'b1;
            start_cnt++;
         end
         en_prev = en_sh;
      end
   end

   task automatic wr(input int a, input int d);
      @(negedge clk);
      wr_en = 1'b1;
      wr_addr = 5'(a);
      wr_data = 10'(d);
      @(posedge clk);
      #1;
      wr_en = 1'b0;
      if (a == 0) en_sh = d[0];
      if (a == 1) sel_sh = 4'(d);
   endtask

   task automatic rd(input int a, output logic [9:0] v);
      @(negedge clk);
      #1;
      rd_addr = 5'(a);
      #1;
      v = rd_data;
   endtask

   task automatic wait_irqs(input int k);
      int t0 = irq_cnt;
      int guard = 0;
      while (irq_cnt < t0 + k && guard < 400) begin
         @(negedge clk);
         guard++;
      end
      #1;
      chk(irq_cnt >= t0 + k, "R5 conversions keep running", irq_cnt - t0, k);
   endtask

   task automatic wait_start();
      int t0 = start_cnt;
      int guard = 0;
      while (start_cnt == t0 && guard < 100) begin
         @(negedge clk);
         guard++;
      end
      #1;
      chk(start_cnt > t0, "R1 start seen", start_cnt - t0, 1);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic compare_all(input string req);
      logic [9:0] v;
      for (int m = 0; m < 10; m++) begin
         rd(16 + m, v);
         chk(v == exp_res[m], req, v, exp_res[m]);
      end
   endtask

   initial begin
      logic [9:0] v;
      int n0;
      for (int m = 0; m < 10; m++) exp_res[m] = '0;
      idle(3);
      #1;
      // R9 reset state
      chk(cv_start == 1'b0, "R9 start low in reset", cv_start, 0);
      chk(eoc_irq == 1'b0, "R9 irq low in reset", eoc_irq, 0);
      rst_n = 1'b1;
      compare_all("R9 results zero after reset");
      rd(0, v);
      chk(v == 10'd0, "R9 enable zero after reset", v, 0);

      // R1 start timing
      wr(1, 4);
      wr(0, 1);
      @(negedge clk); #1;
      chk(cv_start == 1'b0, "R1 no start one cycle after write", cv_start, 0);
      @(negedge clk); #1;
      chk(cv_start == 1'b1, "R1 start two cycles after write", cv_start, 1);
      wait_irqs(1);
      wr(0, 0);
      idle(LAT + 4);
      compare_all("R3 first result");

      // R2 / R3 sweep over every channel field value
      for (int s = 0; s < 16; s++) begin
         wr(1, s);
         wr(0, 1);
         wait_irqs(2);
         chk(last_irq_chan == mapch(4'(s)), "R3 result slot matches channel", last_irq_chan, mapch(4'(s)));
         wr(0, 0);
         idle(LAT + 4);
         compare_all("R3 one-to-one result storage");
      end

      // R8 channel change during a conversion
      wr(1, 3);
      wr(0, 1);
      wait_start();
      wr(1, 7);
      wait_irqs(1);
      chk(last_irq_chan == 4'd3, "R8 running conversion keeps channel", last_irq_chan, 3);
      wait_start();
      chk(m_chan == 4'd7, "R8 next conversion uses new channel", m_chan, 7);
      wr(0, 0);
      idle(LAT + 4);
      compare_all("R8 results after channel change");

      // R7 abort mid-conversion
      wr(1, 5);
      wr(0, 1);
      wait_start();
      n0 = irq_cnt;
      idle(1);
      wr(0, 0);
      idle(LAT + 6);
      chk(irq_cnt == n0, "R7 no irq for aborted conversion", irq_cnt - n0, 0);
      compare_all("R7 no result for aborted conversion");

      // R6 stop: no starts while disabled
      n0 = start_cnt;
      idle(40);
      chk(start_cnt == n0, "R6 no starts while disabled", start_cnt - n0, 0);
      rd(0, v);
      chk(v == 10'd0, "R6 enable reads back zero", v, 0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #1_000_000;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule